// File: doc/BRIEF.md
# Banked Polynomial Coefficient Memory

This block stores the 12-bit coefficients of every polynomial that a lattice key-encapsulation engine keeps between its sampling, transform and multiply stages. One flat space of absolute polynomial slots, each 256 coefficients long, is spread over three banks of unequal size. Slots `0 .. K*K-1` hold the matrix and go to the matrix bank. The `2K` slots from the secret base go to the secret/error bank, with secret polynomials in relative slots `0..K-1` and error polynomials in `K..2K-1`. The `K` slots from the public-vector base go to the public-vector bank. K is a runtime setting up to `KMAX`, and so are both base slots.

Each bank has one registered read and one write per cycle. There is one write port that steers on the absolute slot, and one read port per bank for the engine stage that consumes that class of polynomial. A read returns its data on the cycle after the address is presented. These functional reads are never back-pressured. A debug read port uses a valid/ready handshake. It picks its bank by the slot range the slot falls in, and it only takes a bank's read port in a cycle when that bank's functional read is idle. A request is accepted when `dbg_req_valid` and `dbg_req_ready` are both high. `dbg_req_ready` is low only while the targeted bank is busy with its own functional read. The response appears exactly one cycle after acceptance, and there is no back-pressure on responses.

Top module: `coef_mem_banked`

## Requirements
- R1: An absolute slot s in `0..K*K-1` maps to matrix bank address `{s[3:0], idx[7:0]}`. Data written there is read back on the matrix read port.
- R2: A slot in `cfg_s_base .. cfg_s_base+2K-1` maps to secret/error bank address `{(s-cfg_s_base)[2:0], idx}`. Secret slots (relative `0..K-1`) and error slots (relative `K..2K-1`) share that bank.
- R3: A slot in `cfg_t_base .. cfg_t_base+K-1` maps to public-vector bank address `{(s-cfg_t_base)[1:0], idx}`.
- R4: `*_rd_valid` is high exactly in the cycle after `*_rd_en` was high, and `*_rd_data` holds the addressed coefficient in that cycle.
- R5: When a read and a write reach the same bank address in the same cycle, the read returns the contents from before the write.
- R6: A write whose slot lies in no bank's range under the current K changes no stored coefficient.
- R7: A functional read whose slot lies outside that port's bank range returns zero with `*_rd_valid` high.
- R8: An accepted debug request yields `dbg_rsp_valid` one cycle later, with data from the bank whose range holds the slot. Slots in no range return zero.
- R9: `dbg_req_ready` is low exactly when the debug slot falls in a bank whose functional `*_rd_en` is high in that cycle. A request that is not accepted produces no response.
- R10: After reset all valid outputs are low and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_k | input | 3 | Current K (1..KMAX) |
| cfg_s_base | input | 5 | First absolute slot of the secret/error bank |
| cfg_t_base | input | 5 | First absolute slot of the public-vector bank |
| wr_en | input | 1 | Write strobe |
| wr_slot | input | 5 | Absolute slot of the write |
| wr_idx | input | 8 | Coefficient index of the write |
| wr_data | input | 12 | Coefficient to write |
| ma_rd_en | input | 1 | Matrix bank read strobe |
| ma_rd_slot | input | 5 | Absolute slot for the matrix read |
| ma_rd_idx | input | 8 | Coefficient index for the matrix read |
| ma_rd_valid | output | 1 | Matrix read data valid |
| ma_rd_data | output | 12 | Matrix read data |
| se_rd_en | input | 1 | Secret/error bank read strobe |
| se_rd_slot | input | 5 | Absolute slot for the secret/error read |
| se_rd_idx | input | 8 | Coefficient index for the secret/error read |
| se_rd_valid | output | 1 | Secret/error read data valid |
| se_rd_data | output | 12 | Secret/error read data |
| pv_rd_en | input | 1 | Public-vector bank read strobe |
| pv_rd_slot | input | 5 | Absolute slot for the public-vector read |
| pv_rd_idx | input | 8 | Coefficient index for the public-vector read |
| pv_rd_valid | output | 1 | Public-vector read data valid |
| pv_rd_data | output | 12 | Public-vector read data |
| dbg_req_valid | input | 1 | Debug read request |
| dbg_req_ready | output | 1 | Debug request accepted this cycle |
| dbg_slot | input | 5 | Absolute slot of the debug read |
| dbg_idx | input | 8 | Coefficient index of the debug read |
| dbg_rsp_valid | output | 1 | Debug response valid |
| dbg_rsp_data | output | 12 | Debug response data |

## Verification
A wrong base subtraction or a wrong range bound does not stay hidden. A write lands on an aliased address, and the next read of either location returns the wrong coefficient one cycle after it is issued. Writes that leak from an out-of-range slot show up only when K is raised again and the aliased slot is read back. This is why the bench changes K between writing and reading. A debug read that steals a busy bank shows up in the same cycle, either as a wrong `dbg_req_ready` or as a corrupted functional read one cycle later.

// File: rtl/coef_mem_pkg.sv
package coef_mem_pkg;

  localparam int NBANK = 3;

  typedef enum logic [1:0] {
    BK_MAT  = 2'd0,
    BK_SE   = 2'd1,
    BK_PV   = 2'd2,
    BK_NONE = 2'd3
  } bank_e;

  // number of polynomial slots a bank must hold for a given KMAX
  function automatic int bank_slots(input int b, input int kmax);
    if (b == 0) return kmax * kmax;
    else if (b == 1) return 2 * kmax;
    else return kmax;
  endfunction

  // absolute slot space spanned by all banks
  function automatic int total_slots(input int kmax);
    return kmax * kmax + 3 * kmax;
  endfunction

endpackage

// File: rtl/coef_slot_xlate.sv
module coef_slot_xlate #(
  parameter int SLW  = 5,
  parameter int RSW  = 4,
  parameter int IDXW = 8
) (
  input  logic [SLW-1:0]      slot,
  input  logic [IDXW-1:0]     idx,
  input  logic [SLW-1:0]      base,
  input  logic [SLW:0]        count,
  output logic                hit,
  output logic [RSW+IDXW-1:0] addr
);
  logic [SLW:0] rel;

  always_comb begin
    rel  = {1'b0, slot} - {1'b0, base};
    hit  = (slot >= base) && (rel < count);
    addr = {rel[RSW-1:0], idx};
  end
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int W  = 12,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // nonblocking read of the array: same-address read sees the old word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (re) q <= mem[ra];
  end
endmodule

// File: rtl/coef_mem_banked.sv
module coef_mem_banked
  import coef_mem_pkg::*;
#(
  parameter int CW   = 12,
  parameter int NCO  = 256,
  parameter int KMAX = 4,
  parameter int KW   = $clog2(KMAX + 1),
  parameter int SLW  = $clog2(total_slots(KMAX)),
  parameter int IDXW = $clog2(NCO)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KW-1:0]   cfg_k,
  input  logic [SLW-1:0]  cfg_s_base,
  input  logic [SLW-1:0]  cfg_t_base,
  input  logic            wr_en,
  input  logic [SLW-1:0]  wr_slot,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [CW-1:0]   wr_data,
  input  logic            ma_rd_en,
  input  logic [SLW-1:0]  ma_rd_slot,
  input  logic [IDXW-1:0] ma_rd_idx,
  output logic            ma_rd_valid,
  output logic [CW-1:0]   ma_rd_data,
  input  logic            se_rd_en,
  input  logic [SLW-1:0]  se_rd_slot,
  input  logic [IDXW-1:0] se_rd_idx,
  output logic            se_rd_valid,
  output logic [CW-1:0]   se_rd_data,
  input  logic            pv_rd_en,
  input  logic [SLW-1:0]  pv_rd_slot,
  input  logic [IDXW-1:0] pv_rd_idx,
  output logic            pv_rd_valid,
  output logic [CW-1:0]   pv_rd_data,
  input  logic            dbg_req_valid,
  output logic            dbg_req_ready,
  input  logic [SLW-1:0]  dbg_slot,
  input  logic [IDXW-1:0] dbg_idx,
  output logic            dbg_rsp_valid,
  output logic [CW-1:0]   dbg_rsp_data
);
  localparam int CNTW = SLW + 1;

  logic [SLW-1:0]  base_a  [NBANK];
  logic [CNTW-1:0] cnt_a   [NBANK];
  logic [NBANK-1:0] f_en;
  logic [SLW-1:0]  f_slot  [NBANK];
  logic [IDXW-1:0] f_idx   [NBANK];
  logic [NBANK-1:0] f_hit, w_hit, d_hit, bank_we, d_grant;
  logic [NBANK-1:0] rvalid_q, fhit_q;
  logic [CW-1:0]   q_a     [NBANK];
  bank_e           dsel, dsel_q;
  logic            d_take;

  // per-bank base slot, slot count and functional port
  always_comb begin
    base_a[0] = '0;
    base_a[1] = cfg_s_base;
    base_a[2] = cfg_t_base;
    cnt_a[0]  = CNTW'(cfg_k) * CNTW'(cfg_k);
    cnt_a[1]  = CNTW'(cfg_k) << 1;
    cnt_a[2]  = CNTW'(cfg_k);
    f_en      = {pv_rd_en, se_rd_en, ma_rd_en};
    f_slot[0] = ma_rd_slot; f_idx[0] = ma_rd_idx;
    f_slot[1] = se_rd_slot; f_idx[1] = se_rd_idx;
    f_slot[2] = pv_rd_slot; f_idx[2] = pv_rd_idx;
  end

  // write steering: first matching bank wins, none means dropped
  always_comb begin
    bank_we = '0;
    if (wr_en) begin
      if (w_hit[0])      bank_we[0] = 1'b1;
      else if (w_hit[1]) bank_we[1] = 1'b1;
      else if (w_hit[2]) bank_we[2] = 1'b1;
    end
  end

  // debug routing and back-pressure
  always_comb begin
    if (d_hit[0])      dsel = BK_MAT;
    else if (d_hit[1]) dsel = BK_SE;
    else if (d_hit[2]) dsel = BK_PV;
    else               dsel = BK_NONE;
    dbg_req_ready = (dsel == BK_NONE) ? 1'b1 : !f_en[dsel];
    d_take  = dbg_req_valid && dbg_req_ready;
    d_grant = '0;
    if (d_take && dsel != BK_NONE) d_grant[dsel] = 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int RSW = $clog2(bank_slots(b, KMAX));
    localparam int AWB = RSW + IDXW;

    logic [AWB-1:0] fa, wa, da, ra;

    coef_slot_xlate #(.SLW(SLW), .RSW(RSW), .IDXW(IDXW)) u_fx (
      .slot(f_slot[b]), .idx(f_idx[b]), .base(base_a[b]), .count(cnt_a[b]),
      .hit(f_hit[b]), .addr(fa));
    coef_slot_xlate #(.SLW(SLW), .RSW(RSW), .IDXW(IDXW)) u_wx (
      .slot(wr_slot), .idx(wr_idx), .base(base_a[b]), .count(cnt_a[b]),
      .hit(w_hit[b]), .addr(wa));
    coef_slot_xlate #(.SLW(SLW), .RSW(RSW), .IDXW(IDXW)) u_dx (
      .slot(dbg_slot), .idx(dbg_idx), .base(base_a[b]), .count(cnt_a[b]),
      .hit(d_hit[b]), .addr(da));

    assign ra = f_en[b] ? fa : da;

    coef_bank #(.W(CW), .AW(AWB)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(bank_we[b]), .wa(wa), .wd(wr_data),
      .re(f_en[b] | d_grant[b]), .ra(ra), .q(q_a[b]));

    // functional read owns the bank port whenever it is enabled
    p_func_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      f_en[b] |-> (ra == fa) && !d_grant[b]);
    // out-of-range functional reads come back as zero
    p_oor_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      f_en[b] && !f_hit[b] |=> rvalid_q[b] && fhit_q[b] == 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q      <= '0;
      fhit_q        <= '0;
      dbg_rsp_valid <= 1'b0;
      dsel_q        <= BK_NONE;
    end else begin
      rvalid_q      <= f_en;
      for (int b = 0; b < NBANK; b++)
        if (f_en[b]) fhit_q[b] <= f_hit[b];
      dbg_rsp_valid <= d_take;
      if (d_take) dsel_q <= dsel;
    end
  end

  always_comb begin
    ma_rd_valid  = rvalid_q[0];
    se_rd_valid  = rvalid_q[1];
    pv_rd_valid  = rvalid_q[2];
    ma_rd_data   = fhit_q[0] ? q_a[0] : '0;
    se_rd_data   = fhit_q[1] ? q_a[1] : '0;
    pv_rd_data   = fhit_q[2] ? q_a[2] : '0;
    dbg_rsp_data = (dsel_q == BK_NONE) ? '0 : q_a[dsel_q];
  end

  // at most one bank takes any write
  p_one_bank_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
  // a write is dropped only when no bank range covers its slot
  p_drop_oor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (bank_we == '0) |-> (w_hit == '0));
  // accepted debug request answers exactly one cycle later
  p_dbg_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_valid && dbg_req_ready |=> dbg_rsp_valid);
  // refused debug request gives no response
  p_dbg_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_req_valid && dbg_req_ready) |=> !dbg_rsp_valid);
  // functional read strobe is followed by valid
  p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    se_rd_en |=> se_rd_valid);
endmodule

// File: tb/coef_mem_banked_tb.sv
module coef_mem_banked_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_k = 3'd4;
  logic [4:0]  cfg_s_base = 5'd16, cfg_t_base = 5'd24;
  logic        wr_en = 0;
  logic [4:0]  wr_slot = 0;
  logic [7:0]  wr_idx = 0;
  logic [11:0] wr_data = 0;
  logic        ma_rd_en = 0, se_rd_en = 0, pv_rd_en = 0;
  logic [4:0]  ma_rd_slot = 0, se_rd_slot = 0, pv_rd_slot = 0;
  logic [7:0]  ma_rd_idx = 0, se_rd_idx = 0, pv_rd_idx = 0;
  logic        ma_rd_valid, se_rd_valid, pv_rd_valid;
  logic [11:0] ma_rd_data, se_rd_data, pv_rd_data;
  logic        dbg_req_valid = 0, dbg_req_ready, dbg_rsp_valid;
  logic [4:0]  dbg_slot = 0;
  logic [7:0]  dbg_idx = 0;
  logic [11:0] dbg_rsp_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [11:0] mdl [32*256];

  always #2 clk = ~clk;

  coef_mem_banked dut_i (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [11:0] fv(input int s, input int i);
    return 12'((s * 131 + i * 29 + 3) % 4096);
  endfunction

  // which bank (0 mat,1 se,2 pv,-1 none) holds slot s under the current config
  function automatic int bank_of(input int s);
    int k = int'(cfg_k);
    if (s < k * k) return 0;
    if (s >= cfg_s_base && s < cfg_s_base + 2 * k) return 1;
    if (s >= cfg_t_base && s < cfg_t_base + k) return 2;
    return -1;
  endfunction

  function automatic logic [11:0] exp_port(input int b, input int s, input int i);
    return (bank_of(s) == b) ? mdl[s*256+i] : 12'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; ma_rd_en = 0; se_rd_en = 0; pv_rd_en = 0; dbg_req_valid = 0;
  endtask

  task automatic wr(input int s, input int i, input logic [11:0] d);
    wr_en = 1; wr_slot = 5'(s); wr_idx = 8'(i); wr_data = d;
    if (bank_of(s) >= 0) mdl[s*256+i] = d;
  endtask

  task automatic rd_port(input int b, input int s, input int i, input string req);
    logic [11:0] e;
    e = exp_port(b, s, i);
    idle();
    case (b)
      0: begin ma_rd_en = 1; ma_rd_slot = 5'(s); ma_rd_idx = 8'(i); end
      1: begin se_rd_en = 1; se_rd_slot = 5'(s); se_rd_idx = 8'(i); end
      default: begin pv_rd_en = 1; pv_rd_slot = 5'(s); pv_rd_idx = 8'(i); end
    endcase
    step();
    idle();
    case (b)
      0: begin chk(req, 32'(ma_rd_valid), 1); chk(req, 32'(ma_rd_data), 32'(e)); end
      1: begin chk(req, 32'(se_rd_valid), 1); chk(req, 32'(se_rd_data), 32'(e)); end
      default: begin chk(req, 32'(pv_rd_valid), 1); chk(req, 32'(pv_rd_data), 32'(e)); end
    endcase
  endtask

  task automatic rd_dbg(input int s, input int i, input string req);
    logic [11:0] e;
    int bk;
    bk = bank_of(s);
    e = (bk >= 0) ? mdl[s*256+i] : 12'd0;
    idle();
    dbg_req_valid = 1; dbg_slot = 5'(s); dbg_idx = 8'(i);
    #1 chk({req, " ready"}, 32'(dbg_req_ready), 1);
    step();
    idle();
    chk(req, 32'(dbg_rsp_valid), 1);
    chk(req, 32'(dbg_rsp_data), 32'(e));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 ma valid", 32'(ma_rd_valid), 0);
    chk("R10 se valid", 32'(se_rd_valid), 0);
    chk("R10 pv valid", 32'(pv_rd_valid), 0);
    chk("R10 dbg valid", 32'(dbg_rsp_valid), 0);
    chk("R10 data", 32'(ma_rd_data | se_rd_data | pv_rd_data | dbg_rsp_data), 0);
    rst_n = 1;
    @(negedge clk);

    // fill every slot of the K=4 layout
    for (int s = 0; s < 28; s++)
      for (int i = 0; i < 256; i++) begin
        wr(s, i, fv(s, i));
        step();
      end
    idle();

    // R1/R2/R3 directed mapping corners
    rd_port(0, 0, 0, "R1 mat first");
    rd_port(0, 15, 255, "R1 mat last");
    rd_port(0, 5, 77, "R1 mat mid");
    rd_port(1, 16, 0, "R2 secret first");
    rd_port(1, 19, 255, "R2 secret last");
    rd_port(1, 20, 1, "R2 error first");
    rd_port(1, 23, 255, "R2 error last");
    rd_port(2, 24, 0, "R3 pv first");
    rd_port(2, 27, 255, "R3 pv last");
    // R4: valid drops the cycle after the strobe drops
    step();
    chk("R4 valid low", 32'({ma_rd_valid, se_rd_valid, pv_rd_valid}), 0);

    // R5: read and write the same address in one cycle
    begin
      logic [11:0] old;
      old = mdl[18*256+5];
      idle();
      se_rd_en = 1; se_rd_slot = 5'd18; se_rd_idx = 8'd5;
      wr(18, 5, 12'hABC);
      step();
      idle();
      chk("R5 read old", 32'(se_rd_data), 32'(old));
      rd_port(1, 18, 5, "R5 new after");
    end

    // R9 directed: debug to busy bank refused, other bank accepted
    idle();
    se_rd_en = 1; se_rd_slot = 5'd17; se_rd_idx = 8'd3;
    dbg_req_valid = 1; dbg_slot = 5'd20; dbg_idx = 8'd9;
    #1 chk("R9 busy refuse", 32'(dbg_req_ready), 0);
    step();
    idle();
    chk("R9 no response", 32'(dbg_rsp_valid), 0);
    chk("R9 func intact", 32'(se_rd_data), 32'(mdl[17*256+3]));
    ma_rd_en = 1; ma_rd_slot = 5'd2; ma_rd_idx = 8'd4;
    dbg_req_valid = 1; dbg_slot = 5'd25; dbg_idx = 8'd8;
    #1 chk("R9 other bank ready", 32'(dbg_req_ready), 1);
    step();
    idle();
    chk("R9 dbg data", 32'(dbg_rsp_data), 32'(mdl[25*256+8]));
    chk("R9 mat data", 32'(ma_rd_data), 32'(mdl[2*256+4]));

    // R8 debug routing across ranges and outside
    rd_dbg(3, 10, "R8 dbg mat");
    rd_dbg(21, 200, "R8 dbg error");
    rd_dbg(26, 31, "R8 dbg pv");
    rd_dbg(30, 0, "R8 dbg none");

    // random mix of writes and reads against the model
    for (int n = 0; n < 3000; n++) begin
      int ms, ss, ps, mi, si, pi, ds, di, db;
      logic [11:0] em, es, ep, ed;
      logic dv, ex_rdy;
      idle();
      ms = $urandom_range(0, 15); mi = $urandom_range(0, 255);
      ss = $urandom_range(16, 23); si = $urandom_range(0, 255);
      ps = $urandom_range(24, 27); pi = $urandom_range(0, 255);
      ds = $urandom_range(0, 31);  di = $urandom_range(0, 255);
      ma_rd_en = 1'($urandom_range(0, 1)); ma_rd_slot = 5'(ms); ma_rd_idx = 8'(mi);
      se_rd_en = 1'($urandom_range(0, 1)); se_rd_slot = 5'(ss); se_rd_idx = 8'(si);
      pv_rd_en = 1'($urandom_range(0, 1)); pv_rd_slot = 5'(ps); pv_rd_idx = 8'(pi);
      dv = 1'($urandom_range(0, 1));
      dbg_req_valid = dv; dbg_slot = 5'(ds); dbg_idx = 8'(di);
      em = mdl[ms*256+mi]; es = mdl[ss*256+si]; ep = mdl[ps*256+pi];
      db = bank_of(ds);
      ed = (db >= 0) ? mdl[ds*256+di] : 12'd0;
      ex_rdy = (db < 0) ? 1'b1 :
               (db == 0) ? !ma_rd_en : (db == 1) ? !se_rd_en : !pv_rd_en;
      if ($urandom_range(0, 1) == 1)
        wr($urandom_range(0, 27), $urandom_range(0, 255), 12'($urandom));
      #1 chk("R9 rand ready", 32'(dbg_req_ready), 32'(ex_rdy));
      begin
        logic me, se, pe;
        me = ma_rd_en; se = se_rd_en; pe = pv_rd_en;
        step();
        idle();
        chk("R4 rand ma valid", 32'(ma_rd_valid), 32'(me));
        chk("R4 rand se valid", 32'(se_rd_valid), 32'(se));
        chk("R4 rand pv valid", 32'(pv_rd_valid), 32'(pe));
        if (me) chk("R1 rand ma", 32'(ma_rd_data), 32'(em));
        if (se) chk("R2 rand se", 32'(se_rd_data), 32'(es));
        if (pe) chk("R3 rand pv", 32'(pv_rd_data), 32'(ep));
        chk("R8 rand dbg valid", 32'(dbg_rsp_valid), 32'(dv && ex_rdy));
        if (dv && ex_rdy) chk("R8 rand dbg data", 32'(dbg_rsp_data), 32'(ed));
      end
    end

    // R6/R7: shrink K to 3, try writes and reads outside the ranges
    idle();
    cfg_k = 3'd3;
    @(negedge clk);
    wr(9, 7, 12'h111);  step();
    wr(22, 7, 12'h222); step();
    wr(27, 7, 12'h333); step();
    idle();
    rd_port(0, 10, 7, "R7 mat outside");
    rd_port(1, 22, 7, "R7 se outside");
    rd_port(2, 27, 7, "R7 pv outside");
    rd_port(1, 5, 7, "R7 se below base");
    rd_dbg(9, 7, "R8 dbg gap");
    rd_port(0, 8, 255, "R1 mat last K3");
    cfg_k = 3'd4;
    @(negedge clk);
    rd_port(0, 9, 7, "R6 mat untouched");
    rd_port(1, 22, 7, "R6 se untouched");
    rd_port(2, 27, 7, "R6 pv untouched");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule